// File: doc/BRIEF.md
# Current-Source Trim Calibration Sequencer

This controller trims the current sources of a hybrid current-steering DAC one at a time. It uses a single comparator input. For each source it selects the source under test and the comparison target. It then searches a 6-bit trim word by successive approximation, most significant bit first, and writes the finished word into an external trim RAM through a single-cycle write port. The comparator and the analog sources lie outside the block. The trim RAM also lies outside, and the analog side reads the stored words back from it, so a word written early can serve later as part of a target.

The order is bootstrapped:
- The largest binary source comes first. Its target is the sum of the lower binary sources plus one LSB, 64 LSB in all.
- The reference source comes next. It is a copy of a unary source, and its target is the full binary sum plus one LSB, 128 LSB in all.
- The unary sources come last. Each one is matched to the trimmed reference.

Every untrimmed source sits a few LSB below its ideal value. Each trim code adds 1/8 LSB, up to just under 8 LSB. A programmable settle count sets how many extra cycles each trial value is held before the comparator is sampled.

Top module: `cal_trim_sequencer`

## Requirements
- R1: While reset is held and right after it, `busy_o`, `done_o` and `wr_en_o` are 0 and `trim_o` is 0.
- R2: A one-cycle `start_i` pulse while idle or done raises `busy_o` from the next cycle. A `start_i` pulse while busy has no effect on the sequence. Without a start the block stays idle.
- R3: Sources are calibrated and written in index order 0, 1, 2 … 33. Index 0 is the largest binary source, index 1 is the reference, and indices 2–33 are the unary sources. `wr_addr_o` equals the index and `src_sel_o` holds it while that source is calibrated.
- R4: `tgt_sel_o` encodes the target: 2'd0 is the lower-binary sum plus 1 LSB (used for index 0), 2'd1 is the full binary sum plus 1 LSB (used for index 1), and 2'd2 is the reference source (used for indices 2–33).
- R5: The search runs 6 steps, MSB first. Each step sets the next trial bit, and the bit is cleared when `cmp_above_i` is 1 in the sample cycle. The stored word is therefore the largest code t in 0..63 for which the source plus t eighths of an LSB does not exceed the target, or 0 if none qualifies.
- R6: Each trial value is held for `settle_cycles_i`+1 cycles, and the comparator is sampled in the last of them. One source therefore takes 6·(`settle_cycles_i`+1) busy cycles before its write.
- R7: Each write is a single-cycle `wr_en_o` pulse inside the busy period. In that cycle `wr_data_o` is the final word, and it equals `trim_o`.
- R8: `done_o` rises and `busy_o` falls in the cycle after the write to index 33. `done_o` is then held until the next start.
- R9: A source already above its target stores 0, and a source more than 63 eighths below its target stores 63.
- R10: A settle count of 0 is valid and gives one comparator sample per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that launches a full calibration |
| settle_cycles_i | input | 8 | Extra settle cycles per trial before sampling |
| cmp_above_i | input | 1 | Comparator: source under test exceeds the target |
| src_sel_o | output | 6 | Index of the source under test |
| tgt_sel_o | output | 2 | Target select (0 lower binary sum, 1 full binary sum, 2 reference) |
| trim_o | output | 6 | Trial trim word applied to the source under test |
| wr_en_o | output | 1 | Trim RAM write strobe |
| wr_addr_o | output | 6 | Trim RAM write address |
| wr_data_o | output | 6 | Trim RAM write data |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration of all sources complete |

## Verification
The bench builds the block with its defaults: a 6-bit trim, 32 unary sources (34 RAM entries) and an 8-bit settle counter. This exercises the full bootstrapped chain, in which errors in the binary and reference trims would show up in every unary word. Runs use settle counts of 0 to 3, so the sample timing is checked at its shortest and at longer holds. The behavioural comparator draws random source mismatches of up to ±1 LSB. Directed sources sit far above and far below target to reach both ends of the trim range.

// File: rtl/cal_trim_pkg.sv
// Package: shared encodings for the trim calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package cal_trim_pkg;

    // Comparator target selection seen by the analog side.
    typedef enum logic [1:0] {
        TGT_LOW_BIN  = 2'd0,
        TGT_FULL_BIN = 2'd1,
        TGT_REF      = 2'd2
    } tgt_sel_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WRITE  = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/cal_settle_timer.sv
// Module: cal_settle_timer
// Counts cycles since the last restart and flags when the programmed
// settle count has elapsed. Assumes restart_i is pulsed whenever the
// trial value changes; the count saturates at the limit.
module cal_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Counter: clear on restart, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else if (cnt_q < limit_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry: the current trial has been held long enough.
    always_comb begin
        expired_o = (cnt_q >= limit_i);
    end

endmodule

// File: rtl/cal_sar_reg.sv
// Module: cal_sar_reg
// Successive-approximation trial register. load_i presets the MSB;
// each step_i resolves the current bit from above_i and sets the next
// lower one. Assumes step_i is not asserted once last_o is high,
// except for the final step.
module cal_sar_reg #(
    parameter int TRIM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              above_i,
    output logic [TRIM_W-1:0] trial_o,
    output logic              last_o
);

    localparam int POS_W = (TRIM_W > 1) ? $clog2(TRIM_W) : 1;
    localparam logic [POS_W-1:0] POS_TOP = POS_W'(TRIM_W - 1);

    logic [TRIM_W-1:0] trial_q, trial_nxt;
    logic [POS_W-1:0]  pos_q, pos_nxt;
    logic [TRIM_W-1:0] bit_mask [TRIM_W];

    // One-hot masks, one per bit position.
    generate
        for (genvar g = 0; g < TRIM_W; g++) begin : g_mask
            assign bit_mask[g] = TRIM_W'(1) << g;
        end
    endgenerate

    // Next-trial logic: clear the bit under test if above, arm the next bit.
    always_comb begin
        trial_nxt = trial_q;
        pos_nxt   = pos_q;
        if (load_i) begin
            trial_nxt = bit_mask[TRIM_W-1];
            pos_nxt   = POS_TOP;
        end else if (step_i) begin
            if (above_i) begin
                trial_nxt = trial_nxt & ~bit_mask[pos_q];
            end
            if (pos_q != '0) begin
                trial_nxt = trial_nxt | bit_mask[pos_q - 1'b1];
                pos_nxt   = pos_q - 1'b1;
            end
        end
    end

    // State registers for the trial word and the bit position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_q <= '0;
            pos_q   <= '0;
        end else begin
            trial_q <= trial_nxt;
            pos_q   <= pos_nxt;
        end
    end

    // Outputs: current trial and last-bit flag.
    always_comb begin
        trial_o = trial_q;
        last_o  = (pos_q == '0);
    end

endmodule

// File: rtl/cal_seq_fsm.sv
// Module: cal_seq_fsm
// Walks the sources in bootstrap order, drives the search controls,
// the target selection and the RAM write strobe. Assumes the trial
// register presets its MSB on load_o and finishes after its last step.
module cal_seq_fsm
    import cal_trim_pkg::*;
#(
    parameter int N_SRC = 34,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             expired_i,
    input  logic             sar_last_i,
    output logic             load_o,
    output logic             step_o,
    output logic             restart_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] idx_o,
    output tgt_sel_e         tgt_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_SRC - 1);
    localparam logic [IDX_W-1:0] IDX_REF  = IDX_W'(1);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             launch;

    // Launch decode: start accepted only when not busy.
    always_comb begin
        launch = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    end

    // State and source index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (launch) begin
                        state_q <= ST_SETTLE;
                        idx_q   <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (expired_i && sar_last_i) begin
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (idx_q == IDX_LAST) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_SETTLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Control strobes for the trial register, the timer and the RAM.
    always_comb begin
        load_o    = launch || ((state_q == ST_WRITE) && (idx_q != IDX_LAST));
        step_o    = (state_q == ST_SETTLE) && expired_i;
        restart_o = load_o || step_o;
        wr_en_o   = (state_q == ST_WRITE);
        busy_o    = (state_q == ST_SETTLE) || (state_q == ST_WRITE);
        done_o    = (state_q == ST_DONE);
        idx_o     = idx_q;
    end

    // Target map: binary first, then reference, then unary against reference.
    always_comb begin
        if (idx_q == '0) begin
            tgt_o = TGT_LOW_BIN;
        end else if (idx_q == IDX_REF) begin
            tgt_o = TGT_FULL_BIN;
        end else begin
            tgt_o = TGT_REF;
        end
    end

endmodule

// File: rtl/cal_trim_sequencer.sv
// Module: cal_trim_sequencer (top)
// Trim calibration sequencer: largest binary source, then reference,
// then all unary sources, each searched by successive approximation and
// written to an external trim RAM. Assumes cmp_above_i is valid in the
// sample cycle, i.e. settled within settle_cycles_i+1 cycles of trim_o.
module cal_trim_sequencer
    import cal_trim_pkg::*;
#(
    parameter int TRIM_W   = 6,
    parameter int N_UNARY  = 32,
    parameter int SETTLE_W = 8,
    localparam int N_SRC   = N_UNARY + 2,
    localparam int IDX_W   = $clog2(N_SRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_cycles_i,
    input  logic                cmp_above_i,
    output logic [IDX_W-1:0]    src_sel_o,
    output logic [1:0]          tgt_sel_o,
    output logic [TRIM_W-1:0]   trim_o,
    output logic                wr_en_o,
    output logic [IDX_W-1:0]    wr_addr_o,
    output logic [TRIM_W-1:0]   wr_data_o,
    output logic                busy_o,
    output logic                done_o
);

    logic              load, step, restart, expired, sar_last;
    logic [IDX_W-1:0]  idx;
    logic [TRIM_W-1:0] trial;
    tgt_sel_e          tgt;

    cal_seq_fsm #(
        .N_SRC (N_SRC),
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .expired_i  (expired),
        .sar_last_i (sar_last),
        .load_o     (load),
        .step_o     (step),
        .restart_o  (restart),
        .wr_en_o    (wr_en_o),
        .idx_o      (idx),
        .tgt_o      (tgt),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    cal_settle_timer #(
        .CNT_W (SETTLE_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .limit_i   (settle_cycles_i),
        .expired_o (expired)
    );

    cal_sar_reg #(
        .TRIM_W (TRIM_W)
    ) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .above_i (cmp_above_i),
        .trial_o (trial),
        .last_o  (sar_last)
    );

    // Output mapping: selection, trial word and RAM write port.
    always_comb begin
        src_sel_o = idx;
        tgt_sel_o = tgt;
        trim_o    = trial;
        wr_addr_o = idx;
        wr_data_o = trial;
    end

endmodule

// File: rtl/cal_trim_sequencer_chk.sv
// Module: cal_trim_sequencer_chk
// Protocol checker for the trim calibration sequencer, bound to the top.
module cal_trim_sequencer_chk #(
    parameter int TRIM_W = 6,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [IDX_W-1:0]  src_sel_o,
    input logic [1:0]        tgt_sel_o,
    input logic [TRIM_W-1:0] trim_o,
    input logic              wr_en_o,
    input logic [IDX_W-1:0]  wr_addr_o,
    input logic [TRIM_W-1:0] wr_data_o,
    input logic              busy_o,
    input logic              done_o
);

    // R7
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R7
    wr_port_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (busy_o && (wr_addr_o == src_sel_o) && (wr_data_o == trim_o)));

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R3
    src_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$past(wr_en_o)) |-> $stable(src_sel_o));

    // R3
    src_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_o) && busy_o) |-> (src_sel_o == $past(src_sel_o) + 1'b1));

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(wr_en_o));

    // R4
    unary_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (src_sel_o > IDX_W'(1))) |-> (tgt_sel_o == 2'd2));

endmodule

bind cal_trim_sequencer cal_trim_sequencer_chk #(
    .TRIM_W (TRIM_W),
    .IDX_W  (IDX_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .src_sel_o (src_sel_o),
    .tgt_sel_o (tgt_sel_o),
    .trim_o    (trim_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/cal_trim_sequencer_tb_top.sv
// Bench: behavioural comparator and trim RAM, randomised source mismatch,
// directed corner sources, expected words computed from the requirements.
module cal_trim_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TRIM_W     = 6;
    localparam int N_UNARY    = 32;
    localparam int SETTLE_W   = 8;
    localparam int N_SRC      = N_UNARY + 2;
    localparam int IDX_W      = $clog2(N_SRC);
    localparam int TRIM_MAX   = (1 << TRIM_W) - 1;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                start;
    logic [SETTLE_W-1:0] settle_in;
    logic                cmp_above;
    logic [IDX_W-1:0]    src_sel;
    logic [1:0]          tgt_sel;
    logic [TRIM_W-1:0]   trim;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_addr;
    logic [TRIM_W-1:0]   wr_data;
    logic                busy;
    logic                done;

    // Analog model, values in eighths of an LSB.
    int base8 [N_SRC];
    int ram_m [N_SRC];
    int exp_t [N_SRC];
    int lowsum8;

    int checks = 0;
    int errors = 0;
    int settle_cur = 0;
    int wr_seen = 0;
    int gap = 0;
    bit prev_wr = 1'b0;
    bit mon_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_trim_sequencer #(
        .TRIM_W   (TRIM_W),
        .N_UNARY  (N_UNARY),
        .SETTLE_W (SETTLE_W)
    ) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .settle_cycles_i (settle_in),
        .cmp_above_i     (cmp_above),
        .src_sel_o       (src_sel),
        .tgt_sel_o       (tgt_sel),
        .trim_o          (trim),
        .wr_en_o         (wr_en),
        .wr_addr_o       (wr_addr),
        .wr_data_o       (wr_data),
        .busy_o          (busy),
        .done_o          (done)
    );

    // Behavioural comparator driven by the selected source and target.
    always_comb begin
        int src_v;
        int tgt_v;
        src_v = (int'(src_sel) < N_SRC) ? base8[int'(src_sel)] + int'(trim) : 0;
        case (tgt_sel)
            2'd0:    tgt_v = lowsum8 + 8;
            2'd1:    tgt_v = lowsum8 + base8[0] + ram_m[0] + 8;
            default: tgt_v = base8[1] + ram_m[1];
        endcase
        cmp_above = (src_v > tgt_v);
    end

    // Trim RAM model fed by the write port.
    always @(posedge clk) begin
        if (wr_en && int'(wr_addr) < N_SRC) ram_m[int'(wr_addr)] <= int'(wr_data);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int clamp_trim(input int d);
        if (d < 0) return 0;
        if (d > TRIM_MAX) return TRIM_MAX;
        return d;
    endfunction

    function automatic int exp_tgt(input int idx);
        if (idx == 0) return 0;
        if (idx == 1) return 1;
        return 2;
    endfunction

    // Expected words: largest code keeping the source at or below target (R5).
    function automatic void compute_expected();
        exp_t[0] = clamp_trim(lowsum8 + 8 - base8[0]);
        exp_t[1] = clamp_trim(lowsum8 + base8[0] + exp_t[0] + 8 - base8[1]);
        for (int k = 2; k < N_SRC; k++) begin
            exp_t[k] = clamp_trim(base8[1] + exp_t[1] - base8[k]);
        end
    endfunction

    function automatic int rnd_err();
        return int'($urandom_range(16)) - 8;
    endfunction

    // Sources sit 4 LSB (32 eighths) below ideal plus up to 1 LSB mismatch.
    function automatic void randomize_sources();
        lowsum8  = 63 * 8 + rnd_err();
        base8[0] = 64 * 8 - 32 + rnd_err();
        for (int k = 1; k < N_SRC; k++) base8[k] = 128 * 8 - 32 + rnd_err();
    endfunction

    // Write monitor: order, data, target, settle timing, pulse width.
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_en) begin
                chk(int'(wr_addr) == wr_seen, "R3", "write address", int'(wr_addr), wr_seen);
                chk(!prev_wr, "R7", "write pulse width", int'(prev_wr), 0);
                if (wr_seen < N_SRC) begin
                    chk(int'(wr_data) == exp_t[wr_seen], "R5", "trim word",
                        int'(wr_data), exp_t[wr_seen]);
                    chk(int'(tgt_sel) == exp_tgt(wr_seen), "R4", "target select",
                        int'(tgt_sel), exp_tgt(wr_seen));
                end
                chk(trim == wr_data, "R7", "trim equals write data", int'(trim), int'(wr_data));
                chk(gap == 6 * (settle_cur + 1), "R6", "busy cycles per source",
                    gap, 6 * (settle_cur + 1));
                wr_seen++;
                gap = 0;
            end else if (busy) begin
                gap++;
            end
            prev_wr = wr_en;
        end
    end

    task automatic run_cal(input int settle, input bit mid_start);
        int  cycles;
        bit  lw;
        settle_in  = SETTLE_W'(settle);
        settle_cur = settle;
        compute_expected();
        wr_seen = 0;
        gap     = 0;
        mon_on  = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        cycles = 0;
        lw = 1'b0;
        while (!done && cycles < 20000) begin
            lw = wr_en;
            @(negedge clk);
            cycles++;
            start = (mid_start && (cycles == 100 || cycles == 357));
        end
        start = 1'b0;
        chk(done == 1'b1, "R2", "sequence completes", int'(done), 1);
        chk(lw == 1'b1, "R8", "done follows last write", int'(lw), 1);
        chk(busy == 1'b0, "R8", "busy low at done", int'(busy), 0);
        chk(wr_seen == N_SRC, "R3", "write count", wr_seen, N_SRC);
        repeat (5) @(negedge clk);
        chk(done && !busy && !wr_en, "R8", "done held without start", int'(done), 1);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_2024);
        rst_n = 1'b0;
        start = 1'b0;
        settle_in = '0;
        for (int k = 0; k < N_SRC; k++) begin
            ram_m[k] = 0;
            base8[k] = 0;
        end
        lowsum8 = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !wr_en, "R1", "outputs in reset", int'(busy | done | wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !wr_en, "R1", "outputs after reset", int'(busy | done | wr_en), 0);
        chk(trim == '0, "R1", "trim after reset", int'(trim), 0);
        repeat (10) @(negedge clk);
        chk(!busy && !done, "R2", "idle without start", int'(busy | done), 0);

        // Directed corners with zero settle (R9, R10).
        randomize_sources();
        base8[2] = 1200;
        base8[3] = 900;
        run_cal(0, 1'b0);
        chk(ram_m[2] == 0, "R9", "source above target stores zero", ram_m[2], 0);
        chk(ram_m[3] == TRIM_MAX, "R9", "source far below stores max", ram_m[3], TRIM_MAX);
        chk(ram_m[0] == exp_t[0], "R10", "binary word with zero settle", ram_m[0], exp_t[0]);

        // Random mismatch with longer settle, restarted from done.
        randomize_sources();
        run_cal(3, 1'b0);

        // Start pulses while busy must not disturb the sequence (R2).
        randomize_sources();
        run_cal(1, 1'b1);

        randomize_sources();
        run_cal(2, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule